// File: doc/BRIEF.md
# Branch Trace Flag Queue

This block keeps a short history of branch-trace status words for program-counter tracing in a debug unit. Each slot records three things. The first is a flag saying the captured branch-source information is valid. The second is a flag saying the captured branch-destination information is valid. The third is a 3-bit pointer naming the instruction buffer that held the last instruction executed before the branch. The pointer lets trace software work out how many cycles separated fetch from execution.

Every branch event moves the whole history one place older. Branch events include taken branches, repeat-loop returns and interrupt entries. A new slot enters at the head, and the oldest slot is dropped. A strobe from the fetch stage marks the head slot's captured information as valid. Read strobes from the companion source- and destination-address registers clear the matching flag again, so each capture is consumed once.

The queue has no flow control. It moves on every branch strobe and never stalls or pushes back, so the valid/ready handshake is not used here. All pins are plain control and status pins. A selector chooses which slot appears on the 16-bit read-only status word, and a second output gives the decoded buffer number for that slot.

Top module: `brtrace_flag_queue`

## Requirements
- R1: The queue holds DEPTH (default 4) slots. `sel_i` = 0 shows the newest slot (the head) and `sel_i` = DEPTH-1 shows the oldest. `word_o` is a combinational view of the selected slot.
- R2: The status word layout is: bit 15 = source-valid, bits 14..12 = buffer pointer, bit 7 = destination-valid.
- R3: On each clock edge where `br_evt_i` is 1, every slot moves one place older, and the contents of the oldest slot are discarded.
- R4: The slot that enters at the head on a branch has both valid flags at 0 and takes its pointer from `bufptr_i`.
- R5: When `dst_fetch_i` is 1, both valid flags of the head are set at the next edge. If a branch happens in the same cycle, the set lands on the slot that was the head, which is now at position 1.
- R6: When `src_rd_i` is 1, the source-valid flag of the head is cleared. If a branch happens in the same cycle, the clear applies to the former head, now at position 1.
- R7: When `dst_rd_i` is 1, the destination-valid flag of the head is cleared, with the same rule for a branch in the same cycle.
- R8: If a set and a clear reach the same slot in the same cycle, the set wins.
- R9: `buf_o` is the buffer number of the selected slot. If the pointer p is odd, `buf_o` is p. If p is even, `buf_o` is p+2 (so 0→2, 2→4, 4→6, 6→8).
- R10: A low `rst_n` clears both valid flags in every slot. Reset leaves the pointer fields unchanged.
- R11: Bits 11..8 and 6..0 of `word_o` always read 0. The block has no write path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| br_evt_i | input | 1 | Branch event strobe; moves the queue |
| dst_fetch_i | input | 1 | Branch-destination instruction fetched; sets the head flags |
| src_rd_i | input | 1 | Source-address register read; clears source-valid |
| dst_rd_i | input | 1 | Destination-address register read; clears destination-valid |
| bufptr_i | input | 3 | Buffer pointer captured into the new head slot |
| sel_i | input | 2 | Selects the slot shown on the outputs |
| word_o | output | 16 | Status word of the selected slot |
| buf_o | output | 4 | Decoded buffer number of the selected slot |

## Verification
Every strobe takes effect on the clock edge that samples it. `word_o` and `buf_o` are combinational from the stored slots and `sel_i`, so a result is due one edge after its stimulus. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the updating edge. The vector table moves `sel_i` between deeper slots so that flags cleared or set on a former head can be seen after the queue moves. Reset is asserted mid-run over known pointers so that their retention can be checked at the ports.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  localparam int WORD_W   = 16;
  localparam int BUFPTR_W = 3;
  localparam int SV_BIT   = 15;
  localparam int PTR_LSB  = 12;
  localparam int DV_BIT   = 7;
  localparam int BUF_W    = BUFPTR_W + 1;

  typedef struct packed {
    logic                src_ok;
    logic                dst_ok;
    logic [BUFPTR_W-1:0] ptr;
  } trace_ent_t;
endpackage

// File: rtl/brtrace_slot.sv
module brtrace_slot
  import brtrace_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_i,
  input  trace_ent_t shin_i,
  input  logic       tgt_i,
  input  logic       set_i,
  input  logic       clr_src_i,
  input  logic       clr_dst_i,
  output trace_ent_t ent_o
);
  logic                src_q, dst_q;
  logic [BUFPTR_W-1:0] ptr_q;
  logic                src_base, dst_base, src_d, dst_d;

  // Take the moved-in value first, then apply this slot's set/clear (set wins).
  always_comb begin
    src_base = shift_i ? shin_i.src_ok : src_q;
    dst_base = shift_i ? shin_i.dst_ok : dst_q;
    src_d    = src_base;
    dst_d    = dst_base;
    if (tgt_i) begin
      src_d = set_i | (src_base & ~clr_src_i);
      dst_d = set_i | (dst_base & ~clr_dst_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      dst_q <= 1'b0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  // Pointer storage deliberately has no reset.
  always_ff @(posedge clk) begin
    if (shift_i) ptr_q <= shin_i.ptr;
  end

  assign ent_o = '{src_ok: src_q, dst_ok: dst_q, ptr: ptr_q};
endmodule

// File: rtl/brtrace_bufdec.sv
module brtrace_bufdec
  import brtrace_pkg::*;
(
  input  logic [BUFPTR_W-1:0] ptr_i,
  output logic [BUF_W-1:0]    buf_o
);
  always_comb begin
    if (ptr_i[0]) buf_o = {1'b0, ptr_i};
    else          buf_o = {1'b0, ptr_i} + BUF_W'(2);
  end
endmodule

// File: rtl/brtrace_flag_queue.sv
module brtrace_flag_queue
  import brtrace_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_evt_i,
  input  logic                dst_fetch_i,
  input  logic                src_rd_i,
  input  logic                dst_rd_i,
  input  logic [BUFPTR_W-1:0] bufptr_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [WORD_W-1:0]   word_o,
  output logic [BUF_W-1:0]    buf_o
);
  trace_ent_t                         ent [DEPTH];
  logic [DEPTH-1:0]                   src_vec, dst_vec;
  logic [DEPTH-1:0][BUFPTR_W-1:0]     ptr_vec;
  trace_ent_t                         sel_ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    trace_ent_t shin;
    logic       tgt;
    if (i == 0) begin : g_head
      assign shin = '{src_ok: 1'b0, dst_ok: 1'b0, ptr: bufptr_i};
      assign tgt  = ~br_evt_i;
    end else if (i == 1) begin : g_second
      assign shin = ent[i-1];
      assign tgt  = br_evt_i;
    end else begin : g_deep
      assign shin = ent[i-1];
      assign tgt  = 1'b0;
    end

    brtrace_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_i   (br_evt_i),
      .shin_i    (shin),
      .tgt_i     (tgt),
      .set_i     (dst_fetch_i),
      .clr_src_i (src_rd_i),
      .clr_dst_i (dst_rd_i),
      .ent_o     (ent[i])
    );

    assign src_vec[i] = ent[i].src_ok;
    assign dst_vec[i] = ent[i].dst_ok;
    assign ptr_vec[i] = ent[i].ptr;
  end

  always_comb begin
    sel_ent = ent[0];
    for (int k = 0; k < DEPTH; k++) begin
      if (sel_i == SEL_W'(k)) sel_ent = ent[k];
    end
  end

  always_comb begin
    word_o                                 = '0;
    word_o[SV_BIT]                         = sel_ent.src_ok;
    word_o[PTR_LSB +: BUFPTR_W]            = sel_ent.ptr;
    word_o[DV_BIT]                         = sel_ent.dst_ok;
  end

  brtrace_bufdec u_dec (
    .ptr_i (sel_ent.ptr),
    .buf_o (buf_o)
  );
endmodule

// File: rtl/brtrace_flag_queue_chk.sv
module brtrace_flag_queue_chk
  import brtrace_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            br_evt_i,
  input logic                            dst_fetch_i,
  input logic                            src_rd_i,
  input logic                            dst_rd_i,
  input logic [BUFPTR_W-1:0]             bufptr_i,
  input logic [WORD_W-1:0]               word_o,
  input logic [BUF_W-1:0]                buf_o,
  input logic [DEPTH-1:0]                src_vec,
  input logic [DEPTH-1:0]                dst_vec,
  input logic [DEPTH-1:0][BUFPTR_W-1:0]  ptr_vec
);
  // R3: pointers age by one slot on a branch
  a_r3_age: assert property (@(posedge clk) disable iff (!rst_n)
    br_evt_i |=> ptr_vec[DEPTH-1:1] == $past(ptr_vec[DEPTH-2:0]));

  // R4: fresh head slot
  a_r4_new_entry: assert property (@(posedge clk) disable iff (!rst_n)
    br_evt_i |=> (!src_vec[0] && !dst_vec[0] && ptr_vec[0] == $past(bufptr_i)));

  // R5: fetch sets the head, or the former head when a branch coincides
  a_r5_set_head: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_fetch_i && !br_evt_i) |=> (src_vec[0] && dst_vec[0]));
  a_r5_set_moved: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_fetch_i && br_evt_i) |=> (src_vec[1] && dst_vec[1]));

  // R6 / R7: read strobes clear the head flags
  a_r6_clr_src: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_i && !dst_fetch_i && !br_evt_i) |=> !src_vec[0]);
  a_r7_clr_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_rd_i && !dst_fetch_i && !br_evt_i) |=> !dst_vec[0]);

  // R8: set wins over clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_fetch_i && src_rd_i && dst_rd_i && !br_evt_i) |=> (src_vec[0] && dst_vec[0]));

  // R9: odd pointers name the buffer directly
  a_r9_odd_direct: assert property (@(posedge clk) disable iff (!rst_n)
    word_o[PTR_LSB] |-> buf_o == {1'b0, word_o[PTR_LSB +: BUFPTR_W]});

  // R10: flags held clear while reset is low
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_flags_clear: assert (src_vec == '0 && dst_vec == '0);
    end
  end
endmodule

bind brtrace_flag_queue brtrace_flag_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_evt_i    (br_evt_i),
  .dst_fetch_i (dst_fetch_i),
  .src_rd_i    (src_rd_i),
  .dst_rd_i    (dst_rd_i),
  .bufptr_i    (bufptr_i),
  .word_o      (word_o),
  .buf_o       (buf_o),
  .src_vec     (src_vec),
  .dst_vec     (dst_vec),
  .ptr_vec     (ptr_vec)
);

// File: tb/brtrace_flag_queue_test.sv
`timescale 1ns/1ps
module brtrace_flag_queue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       br_evt_i = 1'b0, dst_fetch_i = 1'b0, src_rd_i = 1'b0, dst_rd_i = 1'b0;
  logic [2:0] bufptr_i = '0;
  logic [1:0] sel_i = '0;
  logic [15:0] word_o;
  logic [3:0]  buf_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  brtrace_flag_queue uut (
    .clk(clk), .rst_n(rst_n), .br_evt_i(br_evt_i), .dst_fetch_i(dst_fetch_i),
    .src_rd_i(src_rd_i), .dst_rd_i(dst_rd_i), .bufptr_i(bufptr_i),
    .sel_i(sel_i), .word_o(word_o), .buf_o(buf_o)
  );

  // nibble7 = {br,fetch,src_rd,dst_rd}, nibble6 = ptr, nibble5 = sel, [15:0] = expected word
  localparam int NV = 15;
  localparam logic [31:0] VECS [NV] = '{
    32'h81001000, 32'h82101000, 32'h85005000, 32'h86301000,
    32'h4000E080, 32'h20006080, 32'h10006000, 32'hC310E080,
    32'h00003000, 32'h4000B080, 32'hA4103080, 32'h0020E080,
    32'h00305000, 32'h8730E080, 32'h7000F080
  };
  localparam logic [15:0] RESV = 16'h0F7F;

  function automatic string tag_of(int i);
    case (i)
      0, 2:     return "R4";
      1, 3, 13: return "R3";
      4:        return "R5";
      5:        return "R6";
      6:        return "R7";
      7:        return "R5 moved";
      8:        return "R1";
      9:        return "R2";
      10, 11, 12: return "R6 moved";
      default:  return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic b, logic f, logic s, logic d, logic [2:0] p, logic [1:0] sl);
    br_evt_i = b; dst_fetch_i = f; src_rd_i = s; dst_rd_i = d; bufptr_i = p; sel_i = sl;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: flags clear after power-on reset, reserved bits zero (R11)
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s);
      #0.1;
      chk("R10 flags", word_o & 16'h8080, 16'h0000);
      chk("R11 reserved", word_o & RESV, 16'h0000);
    end
    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i][31], VECS[i][30], VECS[i][29], VECS[i][28], VECS[i][26:24], VECS[i][21:20]);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, VECS[i][21:20]);
      chk(tag_of(i), word_o, VECS[i][15:0]);
      chk("R11 reserved", word_o & RESV, 16'h0000);
    end
    // R10: mid-run reset keeps pointers, clears flags
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      logic [15:0] exp_rst [4];
      exp_rst = '{16'h7000, 16'h4000, 16'h3000, 16'h6000};
      for (int s = 0; s < 4; s++) begin
        sel_i = 2'(s);
        #0.1;
        chk("R10 reset keeps pointer", word_o, exp_rst[s]);
      end
    end
    // R9: buffer-number decode for every pointer value
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 3'(p), 2'd0);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0);
      chk("R9 decode", {12'd0, buf_o}, (p % 2 == 1) ? 16'(p) : 16'(p + 2));
    end
    // R3: oldest entry dropped after four more branches
    @(negedge clk);
    sel_i = 2'd3;
    #0.1;
    chk("R3 oldest", word_o, 16'h4000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule